// File: doc/BRIEF.md
# Interrupt Coalescing Delay Timer

This block produces a delayed interrupt for one receive or transmit channel of a streaming DMA engine. Each time a packet finishes, the block begins to count an idle interval whose length is set by an 8-bit delay setting. Each unit of the setting is worth 125 clocks. If no new packet begins before the interval runs out, the block issues a single-cycle interrupt pulse and sets a sticky status bit. The effect is that a burst of back-to-back packets produces one interrupt at its tail, while a lone packet is still serviced after a bounded wait.

A packet-start strobe cancels a pending countdown. A packet-end strobe arms the countdown, or restarts it from zero if it is already running. A delay setting of zero turns the feature off completely. Software clears the sticky bit with a one-cycle clear strobe. The reset input is asynchronous and active-low. Its release is synchronised inside the block.

Top module: `irq_delay_timer`

## Requirements
- R1: While reset is applied and in the first cycle after it is released, `dly_irq` and `dly_status` are 0 and no countdown is pending.
- R2: A `pkt_end` sampled at a rising edge with `delay_cfg` = N (1..255), and held there with no later strobe, makes `dly_irq` high after exactly N*125 further rising edges.
- R3: While `delay_cfg` is 0, `pkt_end` arms nothing and `dly_irq` never rises.
- R4: `pkt_start` sampled without `pkt_end` cancels a pending countdown, so no interrupt follows from the earlier packet end.
- R5: When `pkt_start` and `pkt_end` are sampled at the same edge, the countdown is armed as if `pkt_end` came alone.
- R6: A `pkt_end` sampled while a countdown runs restarts it, so the interrupt follows N*125 edges after the newest `pkt_end`.
- R7: `dly_irq` is high for exactly one clock cycle per timeout.
- R8: `dly_status` goes to 1 with `dly_irq` and holds until `status_clr` is sampled high. A `status_clr` sampled at the same edge as a new timeout leaves it at 1.
- R9: A new nonzero `delay_cfg` applied mid-count is compared at the next 125-clock unit boundary. The interrupt fires at the first boundary where the elapsed units reach the setting. Setting `delay_cfg` to 0 mid-count cancels the countdown at the next edge, and it stays cancelled when a nonzero value returns.
- R10: After a timeout the block is idle, and no further interrupt occurs until another `pkt_end`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scatter-gather clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| delay_cfg | input | 8 | Delay in units of 125 clocks; 0 disables |
| pkt_start | input | 1 | One-cycle strobe: a new packet has begun |
| pkt_end | input | 1 | One-cycle strobe: a packet has completed |
| status_clr | input | 1 | One-cycle strobe clearing the sticky status |
| dly_irq | output | 1 | One-cycle delayed interrupt pulse |
| dly_status | output | 1 | Sticky timeout status |

## Verification
The case that is hardest to reach from the ports is a change of setting that lands inside a running countdown. Whether it takes effect depends on where the hidden prescaler and unit count stand when the change arrives. The bench reaches this case by counting clock edges from the arming edge. It changes `delay_cfg` at a known edge, such as edge 300 of a four-unit countdown, so the expected firing edge (edge 375) follows from arithmetic. The same edge counting places a `status_clr` exactly on the timeout edge.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
  localparam int unsigned DEF_DLY_W    = 8;
  localparam int unsigned DEF_UNIT_CLK = 125;

  typedef enum logic [1:0] {
    EV_NONE   = 2'd0,
    EV_ARM    = 2'd1,
    EV_CANCEL = 2'd2,
    EV_FIRE   = 2'd3
  } irqd_event_e;
endpackage

// File: rtl/irqd_prescaler.sv
module irqd_prescaler #(
  parameter int unsigned UNIT_CLK = 125,
  localparam int unsigned PW = (UNIT_CLK > 1) ? $clog2(UNIT_CLK) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam logic [PW-1:0] LAST = PW'(UNIT_CLK - 1);

  logic [PW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign tick   = run && !restart && (cnt_q == LAST);
  assign cnt_en = run || restart || (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (restart || !run) cnt_d = '0;
    else if (tick)       cnt_d = '0;
    else                 cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  p_presc_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  p_presc_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !restart) |=> (cnt_q == '0));
endmodule

// File: rtl/irqd_ctrl.sv
module irqd_ctrl
  import irqd_pkg::*;
#(
  parameter int unsigned DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DLY_W-1:0] delay_cfg,
  input  logic             pkt_start,
  input  logic             pkt_end,
  input  logic             tick,
  output logic             armed,
  output logic             presc_restart,
  output logic             fire
);
  logic             armed_d;
  logic [DLY_W-1:0] units_q, units_d;
  logic [DLY_W:0]   units_inc;
  logic             cfg_zero;
  irqd_event_e      ev;

  assign cfg_zero  = (delay_cfg == '0);
  assign units_inc = {1'b0, units_q} + 1'b1;

  always_comb begin
    ev = EV_NONE;
    if (pkt_end)                          ev = EV_ARM;
    else if (pkt_start)                   ev = EV_CANCEL;
    else if (armed && cfg_zero)           ev = EV_CANCEL;
    else if (armed && tick &&
             (units_inc >= {1'b0, delay_cfg})) ev = EV_FIRE;
  end

  always_comb begin
    armed_d       = armed;
    units_d       = units_q;
    presc_restart = 1'b0;
    fire          = 1'b0;
    unique case (ev)
      EV_ARM: begin
        armed_d       = !cfg_zero;
        units_d       = '0;
        presc_restart = 1'b1;
      end
      EV_CANCEL: begin
        armed_d       = 1'b0;
        units_d       = '0;
        presc_restart = 1'b1;
      end
      EV_FIRE: begin
        armed_d = 1'b0;
        units_d = '0;
        fire    = 1'b1;
      end
      default: begin
        if (armed && tick) units_d = units_inc[DLY_W-1:0];
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      units_q <= '0;
    end else begin
      armed   <= armed_d;
      units_q <= units_d;
    end
  end

  p_start_cancels_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_start && !pkt_end) |=> !armed);
  p_end_arms_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_end && delay_cfg != '0) |=> (armed && units_q == '0));
  p_zero_disarms_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && delay_cfg == '0 && !pkt_end) |=> !armed);
  p_idle_stays_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !pkt_end) |=> !armed);
endmodule

// File: rtl/irqd_status.sv
module irqd_status (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic clr,
  output logic irq,
  output logic status
);
  logic status_d;

  always_comb begin
    status_d = status;
    if (fire)     status_d = 1'b1;
    else if (clr) status_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq    <= 1'b0;
      status <= 1'b0;
    end else begin
      irq    <= fire;
      status <= status_d;
    end
  end

  p_pulse_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  p_irq_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> status);
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (status && !clr) |=> status);
endmodule

// File: rtl/irq_delay_timer.sv
module irq_delay_timer
  import irqd_pkg::*;
#(
  parameter int unsigned DLY_W    = DEF_DLY_W,
  parameter int unsigned UNIT_CLK = DEF_UNIT_CLK
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DLY_W-1:0] delay_cfg,
  input  logic             pkt_start,
  input  logic             pkt_end,
  input  logic             status_clr,
  output logic             dly_irq,
  output logic             dly_status
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       armed, presc_restart, tick, fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  irqd_prescaler #(.UNIT_CLK(UNIT_CLK)) u_presc (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .run     (armed),
    .restart (presc_restart),
    .tick    (tick)
  );

  irqd_ctrl #(.DLY_W(DLY_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .delay_cfg     (delay_cfg),
    .pkt_start     (pkt_start),
    .pkt_end       (pkt_end),
    .tick          (tick),
    .armed         (armed),
    .presc_restart (presc_restart),
    .fire          (fire)
  );

  irqd_status u_stat (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .fire   (fire),
    .clr    (status_clr),
    .irq    (dly_irq),
    .status (dly_status)
  );

  p_zero_no_irq_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    dly_irq |-> ($past(delay_cfg) != '0));
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_int_n |-> (!dly_irq && !dly_status));
endmodule

// File: tb/irq_delay_timer_bench.sv
`timescale 1ns/1ps
module irq_delay_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] delay_cfg;
  logic       pkt_start, pkt_end, status_clr;
  logic       dly_irq, dly_status;
  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  irq_delay_timer u_irq_delay_timer (
    .clk(clk), .rst_n(rst_n), .delay_cfg(delay_cfg), .pkt_start(pkt_start),
    .pkt_end(pkt_end), .status_clr(status_clr), .dly_irq(dly_irq),
    .dly_status(dly_status)
  );

  // {delay setting, expected edges from arming edge to interrupt}
  localparam int VEC [5][2] = '{
    '{1, 125}, '{2, 250}, '{5, 625}, '{17, 2125}, '{255, 31875}
  };

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Called at 1ns after a rising edge; returns edge count of first irq or 0.
  task automatic wait_irq(input int limit, output int lat);
    lat = 0;
    for (int i = 1; i <= limit; i++) begin
      @(posedge clk); #1;
      if (dly_irq) begin lat = i; break; end
    end
  endtask

  task automatic strobe_end();
    pkt_end = 1'b1; @(posedge clk); #1; pkt_end = 1'b0;
  endtask

  task automatic strobe_start();
    pkt_start = 1'b1; @(posedge clk); #1; pkt_start = 1'b0;
  endtask

  task automatic strobe_clr();
    status_clr = 1'b1; @(posedge clk); #1; status_clr = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int lat;
    rst_n = 1'b0; delay_cfg = 8'd0;
    pkt_start = 0; pkt_end = 0; status_clr = 0;
    repeat (3) @(posedge clk); #1;
    check("R1 irq in reset", dly_irq, 0);
    check("R1 status in reset", dly_status, 0);
    rst_n = 1'b1;
    repeat (3) @(posedge clk); #1;
    check("R1 irq after reset", dly_irq, 0);
    check("R1 status after reset", dly_status, 0);

    // Vector table: latency, pulse width, status, idle afterwards, clear.
    for (int v = 0; v < 5; v++) begin
      delay_cfg = 8'(VEC[v][0]);
      strobe_end();
      wait_irq(VEC[v][1] + 10, lat);
      check("R2 latency", lat, VEC[v][1]);
      check("R8 status set", dly_status, 1);
      @(posedge clk); #1;
      check("R7 pulse width", dly_irq, 0);
      wait_irq(300, lat);
      check("R10 no repeat irq", lat, 0);
      check("R8 status held", dly_status, 1);
      strobe_clr();
      check("R8 status cleared", dly_status, 0);
    end

    // R3: setting zero disables
    delay_cfg = 8'd0;
    strobe_end();
    wait_irq(500, lat);
    check("R3 no irq when zero", lat, 0);
    check("R3 status stays clear", dly_status, 0);

    // R4: start cancels
    delay_cfg = 8'd2;
    strobe_end();
    repeat (100) @(posedge clk); #1;
    strobe_start();
    wait_irq(400, lat);
    check("R4 cancelled", lat, 0);

    // R5: simultaneous start and end arm
    delay_cfg = 8'd1;
    pkt_start = 1'b1; pkt_end = 1'b1;
    @(posedge clk); #1;
    pkt_start = 1'b0; pkt_end = 1'b0;
    wait_irq(200, lat);
    check("R5 same-cycle arms", lat, 125);
    strobe_clr();

    // R6: second end restarts
    delay_cfg = 8'd2;
    strobe_end();
    repeat (99) @(posedge clk); #1;
    strobe_end();
    wait_irq(400, lat);
    check("R6 restart latency", lat, 250);
    strobe_clr();

    // R9: lowering setting mid-count fires at next unit boundary (edge 375)
    delay_cfg = 8'd4;
    strobe_end();
    wait_irq(300, lat);
    check("R9 no early fire", lat, 0);
    delay_cfg = 8'd1;
    wait_irq(200, lat);
    check("R9 lowered setting", lat, 75);
    strobe_clr();

    // R9: raising setting mid-count (1 -> 3) fires at edge 375
    delay_cfg = 8'd1;
    strobe_end();
    wait_irq(50, lat);
    check("R9 before raise", lat, 0);
    delay_cfg = 8'd3;
    wait_irq(400, lat);
    check("R9 raised setting", lat, 325);
    strobe_clr();

    // R9: zero mid-count cancels, restoring does not revive
    delay_cfg = 8'd2;
    strobe_end();
    repeat (100) @(posedge clk); #1;
    delay_cfg = 8'd0;
    repeat (50) @(posedge clk); #1;
    delay_cfg = 8'd2;
    wait_irq(400, lat);
    check("R9 zero cancels", lat, 0);

    // R8: clear on the timeout edge leaves status set
    delay_cfg = 8'd1;
    strobe_end();
    wait_irq(124, lat);
    check("R8 before timeout", lat, 0);
    status_clr = 1'b1;
    @(posedge clk); #1;
    status_clr = 1'b0;
    check("R8 irq on timeout edge", dly_irq, 1);
    check("R8 clear loses to set", dly_status, 1);
    strobe_clr();
    check("R8 later clear works", dly_status, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule